// File: doc/BRIEF.md
# Static RAM Fill Sequencer

This block walks a byte-wide static RAM through a fixed run of locations, starting at address zero. At each location it reads the byte already stored there, adds one to it and writes the result back. The RAM is selected for the whole run, so only the active-low write strobe marks a write. The block owns an address register and a data register. The data register is the only driver the block places on the shared bidirectional data bus. At every other time the block leaves the bus at high impedance, so the RAM can drive it.

Each location takes a four-step loop:
1. Capture the bus into the data register.
2. Add one to the data register.
3. Drive the data register onto the bus with the write strobe low.
4. Release the strobe and step the address.

When the address reaches the configured count, the block stops. It then raises a done flag and keeps it high until the next reset.

Top module: `sram_fill_seq`

## Requirements
- R1: Reset state: while `rstN` is low, and in the first cycle after it rises, `memAddr` is 0, `memWeN` is 1 and `done` is 0. The block does not drive `dataBus`.
- R2: In the first step of each location's loop, the data register captures the byte that the RAM presents on `dataBus` at the current address.
- R3: In the second step, the data register is incremented by one, modulo 2**DATA_W, so 8'hFF becomes 8'h00.
- R4: `memWeN` is low for exactly one cycle per location, in the third step of the loop. In that same cycle, and only in that cycle, the block drives the data register value onto `dataBus`.
- R5: `memAddr` holds steady while `memWeN` is low. It advances by one only at the end of the fourth step, after the strobe has gone high again, which gives one new address every four cycles.
- R6: After FILL_COUNT locations, `done` rises as `memAddr` reaches FILL_COUNT. From then on `done` stays 1, `memAddr` stays at FILL_COUNT and `memWeN` stays 1.
- R7: `memCsN` is 0 in every cycle.
- R8: When `memWeN` is high, `dataBus` carries exactly what the RAM drives, because the block's driver is at high impedance.
- R9: After the run, locations 0 to FILL_COUNT-1 each hold their starting byte plus one. Locations from FILL_COUNT upward are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | ADDR_W | RAM address from the address register |
| memCsN | output | 1 | RAM chip select, active low, tied active |
| memWeN | output | 1 | RAM write strobe, active low |
| dataBus | inout | DATA_W | Shared data bus to the RAM |
| done | output | 1 | High once the run has finished |

## Verification
The bench builds the block with its default parameters: an 8-bit address, an 8-bit data word and a run of eight locations. The behavioural RAM therefore spans all 256 bytes, and the locations just past the run show whether the sequencer stops on time. One location inside the run is seeded with 8'hFF, which brings the data-register wrap within reach. The other seeds are distinct, so a wrongly captured or misaddressed byte shows up in the written value. The reference model predicts address, strobe, bus and done on every clock. It then compares the final RAM contents inside and beyond the run.

// File: rtl/sram_fill_pkg.sv
package sram_fill_pkg;

  // Loop steps plus a terminal halt state.
  typedef enum logic [2:0] {
    STEP_LOAD  = 3'd0,
    STEP_BUMP  = 3'd1,
    STEP_WRITE = 3'd2,
    STEP_ADV   = 3'd3,
    STEP_HALT  = 3'd4
  } fillStep_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic ldData;
    logic incData;
    logic enData;
    logic incAddr;
  } fillStrobes_t;

endpackage

// File: rtl/sram_fill_ctrl.sv
module sram_fill_ctrl
  import sram_fill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lastLoc,
  output fillStrobes_t strobes,
  output logic         writeN,
  output logic         halted
);

  fillStep_t curStep;
  fillStep_t nextStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curStep <= STEP_LOAD;
    else       curStep <= nextStep;
  end

  always_comb begin
    nextStep = curStep;
    unique case (curStep)
      STEP_LOAD:  nextStep = STEP_BUMP;
      STEP_BUMP:  nextStep = STEP_WRITE;
      STEP_WRITE: nextStep = STEP_ADV;
      STEP_ADV:   nextStep = lastLoc ? STEP_HALT : STEP_LOAD;
      STEP_HALT:  nextStep = STEP_HALT;
      default:    nextStep = STEP_HALT;
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.ldData  = (curStep == STEP_LOAD);
    strobes.incData = (curStep == STEP_BUMP);
    strobes.enData  = (curStep == STEP_WRITE);
    strobes.incAddr = (curStep == STEP_ADV);
  end

  assign writeN = (curStep != STEP_WRITE);
  assign halted = (curStep == STEP_HALT);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !writeN |=> writeN);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && writeN);

endmodule

// File: rtl/sram_fill_dp.sv
module sram_fill_dp
  import sram_fill_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int FILL_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobes_t      strobes,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic [ADDR_W-1:0] addrQ,
  output logic              lastLoc
);

  localparam logic [ADDR_W:0] LAST_IDX = (ADDR_W+1)'(FILL_COUNT - 1);

  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobes.ldData) begin
      dataQ <= busIn;
    end else if (strobes.incData) begin
      dataQ <= dataQ + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                addrQ <= '0;
    else if (strobes.incAddr) addrQ <= addrQ + ADDR_W'(1);
  end

  assign lastLoc  = ({1'b0, addrQ} == LAST_IDX);
  assign busOut   = dataQ;
  assign busDrive = strobes.enData;

  // R3
  data_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incData |=> dataQ == $past(dataQ) + DATA_W'(1));

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ldData |=> dataQ == $past(busIn));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |=> $stable(addrQ));

endmodule

// File: rtl/sram_fill_seq.sv
module sram_fill_seq
  import sram_fill_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int FILL_COUNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] dataBus,
  output logic              done
);

  fillStrobes_t      strobes;
  logic              lastLoc;
  logic [DATA_W-1:0] busOut;
  logic              busDrive;

  sram_fill_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lastLoc (lastLoc),
    .strobes (strobes),
    .writeN  (memWeN),
    .halted  (done)
  );

  sram_fill_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .FILL_COUNT (FILL_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busIn    (dataBus),
    .busOut   (busOut),
    .busDrive (busDrive),
    .addrQ    (memAddr),
    .lastLoc  (lastLoc)
  );

  assign dataBus = busDrive ? busOut : 'z;
  assign memCsN  = 1'b0;

  // R7
  always_comb begin
    cs_low_chk: assert (memCsN == 1'b0);
  end

  // R6
  done_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> memAddr == ADDR_W'(FILL_COUNT));

  // R4
  drive_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> !memWeN);

endmodule

// File: tb/sim_sram_fill_seq.sv
module sim_sram_fill_seq;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int FC = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memCsN;
  logic          memWeN;
  wire  [DW-1:0] dataBus;
  logic          done;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] ram     [DEPTH];
  logic [DW-1:0] seedMem [DEPTH];
  logic [DW-1:0] refMem  [DEPTH];

  int            mStep;
  int            mAddr;
  logic [DW-1:0] mData;
  bit            running = 1'b1;

  always #5 clk = ~clk;

  sram_fill_seq #(.ADDR_W(AW), .DATA_W(DW), .FILL_COUNT(FC)) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .memAddr (memAddr),
    .memCsN  (memCsN),
    .memWeN  (memWeN),
    .dataBus (dataBus),
    .done    (done)
  );

  // Behavioural RAM: always selected, output enabled while not writing.
  assign dataBus = memWeN ? ram[memAddr] : 'z;
  always @(posedge clk) if (!memWeN) ram[memAddr] <= dataBus;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Cycle model: compare at negedge, then step to the next cycle's state.
  always @(negedge clk) begin
    if (running) begin
      string rq;
      rq = rstN ? "R5" : "R1";
      chk(rq, "memAddr", 32'(memAddr), 32'(mAddr));
      chk(rstN ? "R4" : "R1", "memWeN", 32'(memWeN), 32'(mStep != 2));
      chk(rstN ? "R6" : "R1", "done", 32'(done), 32'(mStep == 4));
      chk("R7", "memCsN", 32'(memCsN), 32'd0);
      if (mStep == 2)
        chk("R4", "bus drive", 32'(dataBus), 32'(mData));
      else
        chk("R8", "bus from RAM", 32'(dataBus), 32'(refMem[mAddr]));
      if (!rstN) begin
        mStep = 0; mAddr = 0; mData = '0;
      end else begin
        case (mStep)
          0: begin mData = refMem[mAddr]; mStep = 1; end   // R2
          1: begin mData = mData + 1'b1; mStep = 2; end    // R3
          2: begin refMem[mAddr] = mData; mStep = 3; end
          3: begin mAddr++; mStep = (mAddr == FC) ? 4 : 0; end
          default: mStep = 4;
        endcase
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      seedMem[i] = DW'(i * 29 + 3);
    end
    seedMem[5] = 8'hFF;   // R3 wrap case
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = seedMem[i];
      refMem[i] = seedMem[i];
    end
    mStep = 0; mAddr = 0; mData = '0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    begin : wait_done
      int n = 0;
      while (!done && n < 1000) begin
        @(posedge clk);
        n++;
      end
      if (!done) begin
        checks++; fails++;
        $display("FAIL watchdog R6: done actual 0 expected 1");
      end
    end
    repeat (12) @(posedge clk);
    #3;
    running = 1'b0;
    // R9: contents after the run
    for (int i = 0; i < FC + 4; i++) begin
      logic [DW-1:0] exp;
      exp = (i < FC) ? DW'(seedMem[i] + 1'b1) : seedMem[i];
      chk("R9", "ram word", 32'(ram[i]), 32'(exp));
    end
    chk("R3", "wrapped word", 32'(ram[5]), 32'h00);
    chk("R6", "final addr", 32'(memAddr), 32'(FC));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule